// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 10-bit successive-approximation converter. A strobe input arms it on its rising edge, which also clears the old result and raises the busy flag. The falling edge of the strobe then starts a bit-by-bit search from the most significant bit down. At each step the block drives the current trial code to an external DAC and reads back one comparator bit. That bit tells it whether the trial value is above the input. The analog path (DAC, comparator, reference, offset current) lies outside the block.

The result is read through two groups that are enabled on their own: an upper group of 8 bits and a lower group of 2 bits. Each has an active-low enable, and tri-state behaviour is modelled as a data bus plus an output-enable flag. An enable asserted mid-conversion shows the partially resolved register. A mode input marks whether the code is to be read as offset binary. It changes nothing in the search.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The result is 10 bits wide and is resolved from bit 9 down to bit 0, one bit per step tick. The launch cycle places 10'b10_0000_0000 on `trial_code`.
- R2: On a step tick the bit under test is cleared if `cmp_over` is 1 (trial above input) and kept if it is 0. The next lower bit is then set as the new candidate. A finished conversion holds the stimulus value exactly.
- R3: A rising edge of `convert_in`, seen after a two-flop synchroniser, takes effect on the third clock edge after it is sampled. It clears `trial_code` to zero, drives `ready_flag` high and aborts any conversion in progress. After reset, `trial_code` is zero and `ready_flag` is low.
- R4: While `convert_in` stays high, no step runs. `trial_code` stays zero and `ready_flag` stays high.
- R5: After `convert_in` falls, `ready_flag` returns low on the (3 + 10·DIV)-th clock edge. The result is then held until the next rising edge of the strobe.
- R6: `hi_oe` is 1 exactly when `hi_en_n` is 0. `hi_data` then carries `trial_code[9:2]`; otherwise it is zero.
- R7: `lo_oe` is 1 exactly when `lo_en_n` is 0. `lo_data` then carries `trial_code[1:0]`; otherwise it is zero.
- R8: An enable asserted while `ready_flag` is high shows the partially resolved register on its group.
- R9: `mode_tag` takes the value of `bipolar_sel` at launch. The code is offset binary and does not depend on the mode: an input of 0 gives 0, mid-scale 512 gives 10'b10_0000_0000, and 1023 gives all ones.
- R10: Step ticks come from a prescaler that fires once every DIV clocks while a conversion runs. The prescaler restarts at launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convert_in | input | 1 | Asynchronous conversion strobe |
| bipolar_sel | input | 1 | Mode marker: 1 means offset-binary bipolar input range |
| cmp_over | input | 1 | Comparator: 1 when the trial value exceeds the input |
| hi_en_n | input | 1 | Active-low enable of the upper 8-bit group |
| lo_en_n | input | 1 | Active-low enable of the lower 2-bit group |
| trial_code | output | 10 | Trial/result code driven to the DAC |
| ready_flag | output | 1 | High from arm to finish, low when the result is valid |
| mode_tag | output | 1 | Mode captured at launch |
| hi_data | output | 8 | Upper result bits 9..2 |
| hi_oe | output | 1 | Output enable of the upper group |
| lo_data | output | 2 | Lower result bits 1..0 |
| lo_oe | output | 1 | Output enable of the lower group |

## Verification
The checker watches several properties on every cycle:
- the clear that follows a strobe rise;
- a frozen code while the block is armed;
- the MSB-only launch code;
- no more than two bits changing per step;
- a held result once the flag is low;
- the flag only ever falling on a step tick;
- the gating of both output groups.

Whether the final code matches the input, the exact latency from strobe fall to ready, an abort and restart mid-search, partial reads and the bipolar end points are shown only by the bench. It compares the block against its behavioural model on every clock and runs directed scenarios.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  parameter int CODE_W = 10;
  parameter int HI_W   = 8;
  localparam int LO_W  = CODE_W - HI_W;
  localparam int IDX_W = $clog2(CODE_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } sar_state_e;

  // Place a candidate one at position idx.
  function automatic logic [CODE_W-1:0] trial_bit(input logic [CODE_W-1:0] code,
                                                  input logic [IDX_W-1:0] idx);
    logic [CODE_W-1:0] r;
    r = code;
    for (int i = 0; i < CODE_W; i++) begin
      if (IDX_W'(i) == idx) r[i] = 1'b1;
    end
    return r;
  endfunction

  // Drop the candidate at idx when the comparator says the sum is too large.
  function automatic logic [CODE_W-1:0] settle_bit(input logic [CODE_W-1:0] code,
                                                   input logic [IDX_W-1:0] idx,
                                                   input logic over);
    logic [CODE_W-1:0] r;
    r = code;
    for (int i = 0; i < CODE_W; i++) begin
      if (IDX_W'(i) == idx && over) r[i] = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/sar_conv_sync.sv
module sar_conv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CNT_W = $clog2(DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt <= '0;
        else if (!run || restart || tick) cnt <= '0;
        else                              cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_rise,
  input  logic              conv_fall,
  input  logic              step_tick,
  input  logic              cmp_over,
  input  logic              bipolar_sel,
  output logic [CODE_W-1:0] code,
  output logic              ready,
  output logic              armed,
  output logic              running,
  output logic              mode_tag
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(CODE_W - 1);

  sar_state_e        st;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] decided;

  assign decided = settle_bit(code, idx, cmp_over);
  assign armed   = (st == ST_ARMED);
  assign running = (st == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      code     <= '0;
      idx      <= '0;
      ready    <= 1'b0;
      mode_tag <= 1'b0;
    end else if (conv_rise) begin
      st    <= ST_ARMED;
      code  <= '0;
      idx   <= TOP;
      ready <= 1'b1;
    end else begin
      case (st)
        ST_ARMED: begin
          if (conv_fall) begin
            st       <= ST_RUN;
            code     <= trial_bit('0, TOP);
            idx      <= TOP;
            mode_tag <= bipolar_sel;
          end
        end
        ST_RUN: begin
          if (step_tick) begin
            if (idx == '0) begin
              code  <= decided;
              st    <= ST_IDLE;
              ready <= 1'b0;
            end else begin
              code <= trial_bit(decided, idx - 1'b1);
              idx  <= idx - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sar_byte_gate.sv
module sar_byte_gate
  import sar_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              hi_en_n,
  input  logic              lo_en_n,
  output logic [HI_W-1:0]   hi_data,
  output logic              hi_oe,
  output logic [LO_W-1:0]   lo_data,
  output logic              lo_oe
);
  logic [1:0] en;
  assign en    = {~hi_en_n, ~lo_en_n};
  assign hi_oe = en[1];
  assign lo_oe = en[0];

  genvar g;
  generate
    for (g = 0; g < CODE_W; g++) begin : g_bit
      if (g >= LO_W) begin : g_hi
        assign hi_data[g-LO_W] = code[g] & en[1];
      end else begin : g_lo
        assign lo_data[g] = code[g] & en[0];
      end
    end
  endgenerate
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convert_in,
  input  logic              bipolar_sel,
  input  logic              cmp_over,
  input  logic              hi_en_n,
  input  logic              lo_en_n,
  output logic [CODE_W-1:0] trial_code,
  output logic              ready_flag,
  output logic              mode_tag,
  output logic [HI_W-1:0]   hi_data,
  output logic              hi_oe,
  output logic [LO_W-1:0]   lo_data,
  output logic              lo_oe
);
  logic conv_rise;
  logic conv_fall;
  logic step_tick;
  logic running;
  logic armed;

  sar_conv_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(convert_in),
    .rise(conv_rise), .fall(conv_fall)
  );

  sar_step_timer #(.DIV(DIV)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(running),
    .restart(conv_rise), .tick(step_tick)
  );

  sar_bit_engine engine_i (
    .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .conv_fall(conv_fall),
    .step_tick(step_tick), .cmp_over(cmp_over), .bipolar_sel(bipolar_sel),
    .code(trial_code), .ready(ready_flag), .armed(armed),
    .running(running), .mode_tag(mode_tag)
  );

  sar_byte_gate gate_i (
    .code(trial_code), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
    .hi_data(hi_data), .hi_oe(hi_oe), .lo_data(lo_data), .lo_oe(lo_oe)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
  import sar_seq_pkg::*;
#(
  parameter int DIV = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_rise,
  input logic              conv_fall,
  input logic              step_tick,
  input logic              running,
  input logic              armed,
  input logic              ready_flag,
  input logic [CODE_W-1:0] trial_code,
  input logic [HI_W-1:0]   hi_data,
  input logic              hi_oe,
  input logic [LO_W-1:0]   lo_data,
  input logic              lo_oe
);
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  assert_rise_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rise |=> (ready_flag && trial_code == '0 && !running));

  assert_hold_while_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !conv_fall && !conv_rise) |=> $stable(trial_code));

  assert_launch_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && conv_fall && !conv_rise) |=> (running && trial_code == MSB_ONLY));

  assert_step_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && step_tick && !conv_rise) |=> ($countones(trial_code ^ $past(trial_code)) <= 2));

  assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_flag && !conv_rise) |=> $stable(trial_code));

  assert_ready_falls_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_flag) |-> $past(step_tick));

  assert_busy_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ready_flag);

  assert_hi_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_oe ? (hi_data == trial_code[CODE_W-1 -: HI_W]) : (hi_data == '0));

  assert_lo_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_oe ? (lo_data == trial_code[LO_W-1:0]) : (lo_data == '0));

  generate
    if (DIV > 1) begin : g_spacing
      assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |=> !step_tick);
    end
  endgenerate
endmodule

bind sar_seq_ctrl sar_seq_chk #(.DIV(DIV)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .conv_fall(conv_fall),
  .step_tick(step_tick), .running(running), .armed(armed),
  .ready_flag(ready_flag), .trial_code(trial_code),
  .hi_data(hi_data), .hi_oe(hi_oe), .lo_data(lo_data), .lo_oe(lo_oe)
);

// File: tb/sar_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convert_in = 1'b0;
  logic bipolar_sel = 1'b0;
  logic hi_en_n = 1'b1;
  logic lo_en_n = 1'b1;
  logic [9:0] vin = '0;
  logic cmp_over;
  logic [9:0] trial_code;
  logic ready_flag, mode_tag, hi_oe, lo_oe;
  logic [7:0] hi_data;
  logic [1:0] lo_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit compare_on = 1'b0;

  always #2.5 clk = ~clk;

  // Comparator stand-in: trial above stimulus.
  assign cmp_over = (trial_code > vin);

  sar_seq_ctrl #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .convert_in(convert_in), .bipolar_sel(bipolar_sel),
    .cmp_over(cmp_over), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
    .trial_code(trial_code), .ready_flag(ready_flag), .mode_tag(mode_tag),
    .hi_data(hi_data), .hi_oe(hi_oe), .lo_data(lo_data), .lo_oe(lo_oe)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit strobe_hist[$];
  int m_phase;   // 0 idle, 1 armed, 2 searching
  int m_code, m_pos, m_cnt, m_rdy, m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_hist = '{0, 0, 0};
      m_phase = 0; m_code = 0; m_pos = 0; m_cnt = 0; m_rdy = 0; m_mode = 0;
    end else begin
      bit seen_now, seen_before;
      seen_now    = strobe_hist[1];
      seen_before = strobe_hist[2];
      strobe_hist.push_front(convert_in);
      void'(strobe_hist.pop_back());
      if (seen_now && !seen_before) begin
        m_phase = 1; m_code = 0; m_rdy = 1; m_cnt = 0;
      end else if (m_phase == 1) begin
        if (!seen_now && seen_before) begin
          m_phase = 2; m_pos = 9; m_code = 512; m_cnt = 0; m_mode = bipolar_sel;
        end
      end else if (m_phase == 2) begin
        if (m_cnt == DIV - 1) begin
          m_cnt = 0;
          if (m_code > int'(vin)) m_code = m_code - (1 << m_pos);
          if (m_pos == 0) begin
            m_phase = 0; m_rdy = 0;
          end else begin
            m_pos = m_pos - 1;
            m_code = m_code + (1 << m_pos);
          end
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      chk(int'(trial_code) == m_code, "R2 trial_code vs model", int'(trial_code), m_code);
      chk(int'(ready_flag) == m_rdy, "R5 ready_flag vs model", int'(ready_flag), m_rdy);
      chk(int'(mode_tag) == m_mode, "R9 mode_tag vs model", int'(mode_tag), m_mode);
      chk(int'(hi_data) == (hi_en_n ? 0 : (m_code / 4)), "R6 hi_data", int'(hi_data),
          hi_en_n ? 0 : (m_code / 4));
      chk(int'(lo_data) == (lo_en_n ? 0 : (m_code % 4)), "R7 lo_data", int'(lo_data),
          lo_en_n ? 0 : (m_code % 4));
      chk(hi_oe == !hi_en_n, "R6 hi_oe", int'(hi_oe), int'(!hi_en_n));
      chk(lo_oe == !lo_en_n, "R7 lo_oe", int'(lo_oe), int'(!lo_en_n));
    end
  end

  task automatic strobe_high(input int cycles);
    convert_in = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic wait_ready_low(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (ready_flag && waited < 2000);
  endtask

  task automatic convert_once(input int v, input bit b, input string tag);
    int w;
    vin = 10'(v);
    bipolar_sel = b;
    strobe_high(3);
    convert_in = 1'b0;
    wait_ready_low(w);
    chk(int'(trial_code) == v, tag, int'(trial_code), v);
    chk(int'(mode_tag) == int'(b), "R9 mode tag after launch", int'(mode_tag), int'(b));
  endtask

  initial begin
    int w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trial_code == '0, "R3 reset code", int'(trial_code), 0);
    chk(ready_flag == 1'b0, "R3 reset ready", int'(ready_flag), 0);
    compare_on = 1'b1;

    // R1/R2: unipolar search over several patterns
    convert_once(0,    1'b0, "R1 result zero");
    convert_once(1023, 1'b0, "R1 result full scale");
    convert_once(341,  1'b0, "R2 result 0101010101");
    convert_once(682,  1'b0, "R2 result 1010101010");
    convert_once(1,    1'b0, "R2 result one");

    // R9: bipolar end points and mid scale
    convert_once(0,    1'b1, "R9 bipolar minimum");
    convert_once(512,  1'b1, "R9 bipolar mid scale");
    convert_once(1023, 1'b1, "R9 bipolar maximum");

    // R4: strobe held high, nothing advances
    vin = 10'd300;
    strobe_high(40);
    chk(trial_code == '0, "R4 code while strobe high", int'(trial_code), 0);
    chk(ready_flag == 1'b1, "R4 ready while strobe high", int'(ready_flag), 1);
    // R5/R10: exact latency from strobe fall to ready low
    convert_in = 1'b0;
    wait_ready_low(w);
    chk(w == 3 + 10 * DIV, "R10 latency to ready low", w, 3 + 10 * DIV);
    chk(int'(trial_code) == 300, "R5 result after held strobe", int'(trial_code), 300);
    repeat (20) @(negedge clk);
    chk(int'(trial_code) == 300, "R5 result held", int'(trial_code), 300);

    // R3: abort mid-search and restart
    vin = 10'd700;
    strobe_high(3);
    convert_in = 1'b0;
    repeat (15) @(negedge clk);
    chk(ready_flag == 1'b1, "R3 still busy before abort", int'(ready_flag), 1);
    vin = 10'd100;
    strobe_high(3);
    chk(trial_code == '0, "R3 abort clears code", int'(trial_code), 0);
    chk(ready_flag == 1'b1, "R3 abort keeps ready high", int'(ready_flag), 1);
    convert_in = 1'b0;
    wait_ready_low(w);
    chk(int'(trial_code) == 100, "R3 result after restart", int'(trial_code), 100);

    // R8: partial read of the upper group mid-search
    vin = 10'd1023;
    strobe_high(3);
    convert_in = 1'b0;
    repeat (3 + 2 * DIV + 1) @(negedge clk);
    hi_en_n = 1'b0;
    #1;
    chk(hi_oe == 1'b1, "R8 partial hi_oe", int'(hi_oe), 1);
    chk(int'(hi_data) == 8'hE0, "R8 partial hi_data", int'(hi_data), 8'hE0);
    chk(ready_flag == 1'b1, "R8 still converting", int'(ready_flag), 1);
    @(negedge clk);
    hi_en_n = 1'b1;
    wait_ready_low(w);

    // R6/R7: groups enabled separately on a finished result
    vin = 10'd0;
    convert_once(642, 1'b0, "R2 result 1010000010");
    lo_en_n = 1'b0;
    #1;
    chk(hi_oe == 1'b0 && hi_data == 8'h00, "R6 upper group idle", int'(hi_data), 0);
    chk(lo_oe == 1'b1 && int'(lo_data) == 2, "R7 lower group", int'(lo_data), 2);
    @(negedge clk);
    hi_en_n = 1'b0;
    lo_en_n = 1'b1;
    #1;
    chk(int'(hi_data) == 160, "R6 upper group", int'(hi_data), 160);
    chk(lo_oe == 1'b0 && lo_data == 2'b00, "R7 lower group idle", int'(lo_data), 0);
    @(negedge clk);
    hi_en_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R5 watchdog expired got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule